// File: doc/BRIEF.md
# SPI Host-Side FIFO and Event Front End

This block is the processor-facing half of an SPI controller. Software sees a small word-addressed register window. It holds a mode word with the global enable and two FIFO threshold fields, a live event word, an interrupt mask, a port for writing transmit characters and a port for reading received characters. Behind the window sit two 32-entry byte FIFOs. One feeds outgoing characters to a separate shift engine. The other collects the characters that the engine shifts in. Both sides of the engine link use a plain valid/ready byte handshake, and the engine reports the end of a commanded transfer with a one-cycle pulse.

Software turns the interface off and on again to flush both FIFOs before each transfer. It pushes characters through the transmit port and polls or takes interrupts on the event word. That word reports FIFO occupancy, threshold crossings, a sticky transfer-complete flag and the current number of received bytes. The interrupt line is the OR of every event bit that the mask enables.

Top module: `spi_host_frontend`

## Requirements
- R1: After reset the mode word and the mask read 0 and `irq` is low. The event word reads 0x0000_8100, meaning the transmit side is empty and not full.
- R2: Mode bit 31 is the global enable. Writing the mode word with bit 31 clear empties both FIFOs on that same clock edge. While the enable is clear, transmit-port writes are dropped, `rx_ready` is low, and `xfer_done` has no effect.
- R3: A write to address 3 pushes `reg_wdata[7:0]` into the 32-entry transmit FIFO. A write to a full FIFO is dropped. `tx_valid` is high whenever the FIFO holds a byte, and `tx_data` is then the oldest byte. An entry is removed on a clock edge where `tx_valid` and `tx_ready` are both high.
- R4: The engine pushes `rx_data` into the 32-entry receive FIFO on an edge where `rx_valid` and `rx_ready` are both high. `rx_ready` is high only while the enable is set and the FIFO is not full. A read of address 4 returns the oldest byte in bits 7:0, with the other bits 0, and pops it. A read of an empty FIFO returns 0 and pops nothing.
- R5: Event word (address 1) bits 29:24 hold the receive FIFO count, from 0 to 32. Bit 15 is set when the transmit FIFO is empty, bit 9 when the receive FIFO is not empty, and bit 8 when the transmit FIFO is not full. Bits 31:30, 13, 10 and 7:0 read 0.
- R6: Event bit 14 is a sticky done flag. It is set by a `xfer_done` pulse while the interface is enabled. It is cleared by writing the event word with bit 14 set. Writes of 0 to bit 14 leave it unchanged. A set and a clear on the same edge leave it set.
- R7: Mode bits 13:8 hold a transmit threshold. Event bit 11 is set while the transmit count is below that threshold. Mode bits 5:0 hold a receive threshold. Event bit 12 is set while the receive count is above that threshold.
- R8: `irq` is the OR of the bitwise AND of the event word and the mask (address 2). When the mask is 0, `irq` stays low.
- R9: The addresses are 0 for mode, 1 for event, 2 for mask, 3 for the transmit port and 4 for the receive port. The mode word reads back only bits 31, 13:8 and 5:0. The mask reads back all 32 bits. Addresses 3, 5, 6 and 7 read 0. `reg_rdata` is 0 unless `reg_rd` is high, and it is valid in the same cycle as `reg_rd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the strobe |
| tx_valid | output | 1 | A transmit byte is offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered byte |
| tx_data | output | 8 | Oldest transmit byte |
| rx_valid | input | 1 | Engine presents a received byte |
| rx_ready | output | 1 | Receive FIFO can take a byte |
| rx_data | input | 8 | Received byte from the engine |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situations to reach are the ones where several things happen on one edge. Examples are a mode write that clears the enable while the engine is still pushing or popping, a done pulse landing on the cycle that software clears the flag, and FIFO pushes arriving exactly at the full boundary. Directed sequences overfill both FIFOs by two entries and then drain them past empty. They also fire the done pulse together with its clear, and disable the interface with traffic in flight. A long seeded random phase then mixes port writes and reads, engine handshakes, mode rewrites with random thresholds and mask changes on every cycle, against a queue-based model of the requirements.

// File: rtl/spi_fe_pkg.sv
// Package: shared register addresses and bit positions of the SPI front end.
// Assumes a word-addressed register window with three address bits.
package spi_fe_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int CHAR_W = 8;
    localparam int THR_W  = 6;

    typedef enum logic [ADDR_W-1:0] {
        A_MODE   = 3'd0,
        A_EVENT  = 3'd1,
        A_MASK   = 3'd2,
        A_TXPORT = 3'd3,
        A_RXPORT = 3'd4
    } reg_sel_e;

    // Mode word fields
    localparam int MODE_EN_BIT   = 31;
    localparam int MODE_TXTHR_LO = 8;
    localparam int MODE_RXTHR_LO = 0;

    // Event word fields
    localparam int EV_TXEMPTY   = 15;
    localparam int EV_DONE      = 14;
    localparam int EV_RXABOVE   = 12;
    localparam int EV_TXBELOW   = 11;
    localparam int EV_RXNE      = 9;
    localparam int EV_TXNF      = 8;
    localparam int EV_RXCNT_LO  = 24;
    localparam int EV_RXCNT_W   = 6;

endpackage

// File: rtl/spi_fe_fifo.sv
// Module: synchronous byte FIFO with flush.
// Does: stores up to DEPTH entries, drops pushes when full, ignores pops when
// empty, and presents the oldest entry (zero when empty) on head.
// Assumes: flush has priority over push and pop on the same edge.
module spi_fe_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             push_ok;
    logic             pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH-1.
    function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; data needs no reset since count gates its visibility.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy tracking with flush priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (pop_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/spi_fe_event.sv
// Module: event word assembly and masked interrupt.
// Does: builds the live event word from FIFO counts, thresholds and the done
// flag, then ANDs it with the mask and reduces it to one interrupt line.
// Assumes: DEPTH is at most 63 so the receive count fits its 6-bit field.
module spi_fe_event
    import spi_fe_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic [CNT_W-1:0]  rx_cnt,
    input  logic [THR_W-1:0]  tx_thr,
    input  logic [THR_W-1:0]  rx_thr,
    input  logic              done_q,
    input  logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] event_word,
    output logic              irq
);

    // Place each status flag and the receive count at its event position.
    always_comb begin
        event_word                               = '0;
        event_word[EV_RXCNT_LO +: EV_RXCNT_W]    = EV_RXCNT_W'(rx_cnt);
        event_word[EV_TXEMPTY]                   = (tx_cnt == '0);
        event_word[EV_DONE]                      = done_q;
        event_word[EV_RXABOVE]                   = (int'(rx_cnt) > int'(rx_thr));
        event_word[EV_TXBELOW]                   = (int'(tx_cnt) < int'(tx_thr));
        event_word[EV_RXNE]                      = (rx_cnt != '0);
        event_word[EV_TXNF]                      = (tx_cnt != CNT_W'(DEPTH));
    end

    // Interrupt is any enabled event bit.
    assign irq = |(event_word & mask_q);

endmodule

// File: rtl/spi_fe_regs.sv
// Module: register window of the SPI front end.
// Does: holds the mode, mask and done state, decodes accesses into FIFO
// strobes, and drives the combinational read data.
// Assumes: one access per cycle; reads and writes are not issued together.
module spi_fe_regs
    import spi_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] event_word,
    input  logic [CHAR_W-1:0] rx_head,
    output logic              mode_en,
    output logic [THR_W-1:0]  tx_thr,
    output logic [THR_W-1:0]  rx_thr,
    output logic [DATA_W-1:0] mask_q,
    output logic              done_q,
    output logic              flush,
    output logic              tx_push,
    output logic              rx_pop
);

    logic wr_mode;
    logic wr_event;
    logic wr_mask;
    logic [DATA_W-1:0] mode_word;

    assign wr_mode  = reg_wr && (reg_addr == A_MODE);
    assign wr_event = reg_wr && (reg_addr == A_EVENT);
    assign wr_mask  = reg_wr && (reg_addr == A_MASK);

    // Flush on the disabling write itself and while the interface is off.
    assign flush   = (wr_mode && !reg_wdata[MODE_EN_BIT]) || !mode_en;
    assign tx_push = reg_wr && (reg_addr == A_TXPORT) && mode_en;
    assign rx_pop  = reg_rd && (reg_addr == A_RXPORT);

    // Mode and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_en <= 1'b0;
            tx_thr  <= '0;
            rx_thr  <= '0;
            mask_q  <= '0;
        end else begin
            if (wr_mode) begin
                mode_en <= reg_wdata[MODE_EN_BIT];
                tx_thr  <= reg_wdata[MODE_TXTHR_LO +: THR_W];
                rx_thr  <= reg_wdata[MODE_RXTHR_LO +: THR_W];
            end
            if (wr_mask) begin
                mask_q <= reg_wdata;
            end
        end
    end

    // Sticky done flag: set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (xfer_done && mode_en) begin
            done_q <= 1'b1;
        end else if (wr_event && reg_wdata[EV_DONE]) begin
            done_q <= 1'b0;
        end
    end

    // Readable image of the mode word.
    always_comb begin
        mode_word                              = '0;
        mode_word[MODE_EN_BIT]                 = mode_en;
        mode_word[MODE_TXTHR_LO +: THR_W]      = tx_thr;
        mode_word[MODE_RXTHR_LO +: THR_W]      = rx_thr;
    end

    // Read data multiplexer, zero when no read is requested.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_MODE:   reg_rdata = mode_word;
                A_EVENT:  reg_rdata = event_word;
                A_MASK:   reg_rdata = mask_q;
                A_RXPORT: reg_rdata = {{(DATA_W-CHAR_W){1'b0}}, rx_head};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_host_frontend.sv
// Module: top of the SPI host-side FIFO and event front end.
// Does: joins the register window, the transmit and receive FIFOs and the
// event logic, and exposes byte handshakes toward the shift engine.
// Assumes: the shift engine honours valid/ready and pulses xfer_done once.
module spi_host_frontend
    import spi_fe_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              xfer_done,
    output logic              irq
);

    logic              mode_en;
    logic [THR_W-1:0]  tx_thr;
    logic [THR_W-1:0]  rx_thr;
    logic [DATA_W-1:0] mask_q;
    logic              done_q;
    logic              flush;
    logic              tx_push;
    logic              rx_pop;
    logic [DATA_W-1:0] event_word;
    logic [CHAR_W-1:0] rx_head;
    logic [CNT_W-1:0]  tx_cnt;
    logic [CNT_W-1:0]  rx_cnt;
    logic              tx_empty;
    logic              tx_full;
    logic              rx_empty;
    logic              rx_full;

    assign tx_valid = !tx_empty;
    assign rx_ready = mode_en && !rx_full;

    spi_fe_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .xfer_done  (xfer_done),
        .event_word (event_word),
        .rx_head    (rx_head),
        .mode_en    (mode_en),
        .tx_thr     (tx_thr),
        .rx_thr     (rx_thr),
        .mask_q     (mask_q),
        .done_q     (done_q),
        .flush      (flush),
        .tx_push    (tx_push),
        .rx_pop     (rx_pop)
    );

    spi_fe_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (tx_push),
        .wdata (reg_wdata[CHAR_W-1:0]),
        .pop   (tx_valid && tx_ready),
        .head  (tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    spi_fe_fifo #(.DEPTH(DEPTH), .W(CHAR_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .push  (rx_valid && rx_ready),
        .wdata (rx_data),
        .pop   (rx_pop),
        .head  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    spi_fe_event #(.DEPTH(DEPTH)) u_event (
        .tx_cnt     (tx_cnt),
        .rx_cnt     (rx_cnt),
        .tx_thr     (tx_thr),
        .rx_thr     (rx_thr),
        .done_q     (done_q),
        .mask_q     (mask_q),
        .event_word (event_word),
        .irq        (irq)
    );

endmodule

// File: rtl/spi_host_frontend_chk.sv
// Module: assertion checker for the SPI front end, bound to the top.
// Does: checks FIFO bounds, flush on disable, handshake stability, the
// sticky done flag and interrupt masking.
module spi_host_frontend_chk #(
    parameter int DEPTH = 32,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             rx_ready,
    input logic             irq,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic             mode_en,
    input logic [31:0]      mask_q,
    input logic             done_q
);

    // R2: a disabled interface holds both FIFOs empty.
    p_disabled_flushed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |-> (tx_cnt == '0) && (rx_cnt == '0));

    // R3: transmit occupancy never exceeds the depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_cnt) <= DEPTH);

    // R3: an offered byte waits unchanged until accepted.
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(reg_wr && reg_addr == 3'd0 && !reg_wdata[31]))
        |=> tx_valid && $stable(tx_data));

    // R4: the engine is only told ready when a slot is free.
    p_rx_ready_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (int'(rx_cnt) < DEPTH) && mode_en);

    // R4: receive occupancy never exceeds the depth.
    p_rx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_cnt) <= DEPTH);

    // R6: done stays set without a one-to-clear write.
    p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(reg_wr && reg_addr == 3'd1 && reg_wdata[14])) |=> done_q);

    // R8: an all-zero mask keeps the interrupt low.
    p_mask_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

endmodule

bind spi_host_frontend spi_host_frontend_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .mode_en   (mode_en),
    .mask_q    (mask_q),
    .done_q    (done_q)
);

// File: tb/spi_host_frontend_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked against a
// queue model of the requirements.
module spi_host_frontend_bench;

    localparam int DEPTH = 32;
    localparam time TCK = 20ns;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr, reg_rd, tx_ready, rx_valid, xfer_done;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        tx_valid, rx_ready, irq;
    logic [7:0]  tx_data, rx_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model state
    logic [7:0]  mq[$];
    logic [7:0]  rq[$];
    logic        m_en;
    logic [5:0]  m_txthr, m_rxthr;
    logic [31:0] m_mask;
    logic        m_done;

    always #(TCK/2) clk = ~clk;

    spi_host_frontend u_spi_host_frontend (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .xfer_done(xfer_done), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_event();
        logic [31:0] e = '0;
        e[29:24] = 6'(rq.size());
        e[15]    = (mq.size() == 0);
        e[14]    = m_done;
        e[12]    = (rq.size() > int'(m_rxthr));
        e[11]    = (mq.size() < int'(m_txthr));
        e[9]     = (rq.size() != 0);
        e[8]     = (mq.size() != DEPTH);
        return e;
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return {m_en, 17'b0, m_txthr, 2'b0, m_rxthr};
            3'd1: return exp_event();
            3'd2: return m_mask;
            3'd4: return (rq.size() != 0) ? {24'b0, rq[0]} : 32'b0;
            default: return 32'b0;
        endcase
    endfunction

    // One cycle: compare outputs before the edge, then advance the model.
    task automatic cyc(string rtag);
        bit tx_pop, tx_push, rx_push, rx_pop, new_en;
        #2;
        check("R3 tx_valid", tx_valid, mq.size() != 0);
        check("R3 tx_data", tx_data, (mq.size() != 0) ? mq[0] : 8'h00);
        check("R4 rx_ready", rx_ready, m_en && rq.size() < DEPTH);
        check("R8 irq", irq, |(exp_event() & m_mask));
        if (reg_rd) begin
            string t = rtag;
            if (t == "") t = (reg_addr == 3'd1) ? "R5" : (reg_addr == 3'd4) ? "R4" : "R9";
            check({t, " rdata"}, reg_rdata, exp_read(reg_addr));
        end
        tx_pop  = (mq.size() != 0) && tx_ready;
        tx_push = reg_wr && reg_addr == 3'd3 && m_en && mq.size() < DEPTH;
        rx_push = rx_valid && m_en && rq.size() < DEPTH;
        rx_pop  = reg_rd && reg_addr == 3'd4 && rq.size() != 0;
        if (tx_pop) void'(mq.pop_front());
        if (tx_push) mq.push_back(reg_wdata[7:0]);
        if (rx_pop) void'(rq.pop_front());
        if (rx_push) rq.push_back(rx_data);
        if (xfer_done && m_en) m_done = 1'b1;
        else if (reg_wr && reg_addr == 3'd1 && reg_wdata[14]) m_done = 1'b0;
        new_en = m_en;
        if (reg_wr && reg_addr == 3'd0) begin
            new_en  = reg_wdata[31];
            m_txthr = reg_wdata[13:8];
            m_rxthr = reg_wdata[5:0];
        end
        if (reg_wr && reg_addr == 3'd2) m_mask = reg_wdata;
        m_en = new_en;
        if (!new_en) begin mq.delete(); rq.delete(); end
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; xfer_done = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc("");
    endtask

    task automatic rd(logic [2:0] a, string tag);
        reg_rd = 1; reg_addr = a;
        cyc(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc("");
    endtask

    initial begin
        #(TCK * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h2468_ace1));
        rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
        tx_ready = 0; rx_valid = 0; rx_data = 0; xfer_done = 0;
        m_en = 0; m_txthr = 0; m_rxthr = 0; m_mask = 0; m_done = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd2, "R1");
        check("R1 irq", irq, 1'b0);

        // R2 disabled: tx writes dropped, done ignored
        wr(3'd3, 32'h5A); xfer_done = 1; cyc("");
        rd(3'd1, "R2");

        // R7 thresholds, R3 fill beyond full then drain
        wr(3'd0, 32'h8000_0403);
        for (int i = 0; i < 3; i++) wr(3'd3, 32'h10 + i);
        rd(3'd1, "R7");
        for (int i = 0; i < DEPTH - 1; i++) wr(3'd3, 32'h40 + i);
        rd(3'd1, "R3");
        tx_ready = 1; idle(DEPTH + 2); tx_ready = 0;
        rd(3'd1, "R3");

        // R4 overfill receive, read out, empty read
        rx_valid = 1;
        for (int i = 0; i < DEPTH + 2; i++) begin rx_data = 8'(i * 7 + 1); cyc(""); end
        rx_valid = 0;
        rd(3'd1, "R5");
        check("R4 rx_ready full", rx_ready, 1'b0);
        for (int i = 0; i < DEPTH + 1; i++) rd(3'd4, "R4");
        rd(3'd1, "R7");

        // R6 done sticky and clear priority, R8 mask
        wr(3'd2, 32'h0000_4000);
        xfer_done = 1; cyc("");
        check("R8 irq done", irq, 1'b1);
        wr(3'd1, 32'h0);
        rd(3'd1, "R6");
        reg_wr = 1; reg_addr = 3'd1; reg_wdata = 32'h4000; xfer_done = 1; cyc("");
        rd(3'd1, "R6");
        wr(3'd1, 32'h4000);
        rd(3'd1, "R6");
        wr(3'd2, 32'h0);

        // R2 disable with traffic in flight
        for (int i = 0; i < 5; i++) wr(3'd3, 32'hA0 + i);
        rx_valid = 1; rx_data = 8'h77; cyc("");
        tx_ready = 1; reg_wr = 1; reg_addr = 3'd0; reg_wdata = 32'h0000_0102; cyc("");
        rx_valid = 0; tx_ready = 0;
        rd(3'd1, "R2");
        check("R2 rx_ready off", rx_ready, 1'b0);
        rd(3'd0, "R9"); rd(3'd6, "R9");

        // Random phase
        wr(3'd0, 32'h8000_0810);
        for (int it = 0; it < 4000; it++) begin
            int k = $urandom_range(0, 15);
            tx_ready = $urandom_range(0, 1);
            rx_valid = ($urandom_range(0, 2) == 0);
            rx_data  = 8'($urandom);
            case (k)
                0, 1, 2, 3, 4: wr(3'd3, $urandom);
                5, 6, 7, 8:    rd(3'd4, "");
                9, 10:         rd(3'd1, "");
                11: begin xfer_done = 1; cyc(""); end
                12: wr(3'd2, $urandom);
                13: wr(3'd1, $urandom);
                14: wr(3'd0, {($urandom_range(0, 7) != 0), 17'b0, 6'($urandom), 2'b0, 6'($urandom)});
                default: rd(3'($urandom_range(0, 7)), "");
            endcase
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule